// File: doc/BRIEF.md
# Octant-Folding Phase Front End for a Numerically Controlled Oscillator

This block surrounds a first-octant rotation core inside a numerically controlled oscillator. On every clock it steps a 16-bit phase register by a tuning word. It adds a separate offset word to form the instantaneous phase. It then reduces that phase to an angle in the range 0 to pi/4, which it hands to an external sine/cosine core. The three highest phase bits give the octant. They travel alongside the sample while the core works, so each result that comes back can be mapped to its own slice of the circle.

When the core returns a first-octant cosine/sine pair, the block can exchange the two values, then negate either of them in two's complement. The result is a full-circle quadrature pair. The output frequency is the tuning word times the clock rate divided by 2^16. The core latency is a parameter, and the octant delay line is built to match it.

Top module: `ncof_top`

## Requirements
- R1: A synchronous active-high reset clears the phase register and drops both valid outputs. The first sample sent to the core after reset uses phase = offset word.
- R2: While not in reset, the phase register grows by the tuning word on every clock, modulo 2^16.
- R3: The instantaneous phase of a sample is the phase register value plus the offset word, modulo 2^16.
- R4: The angle sent to the core is phase bits [12:0]. When phase bit 13 is 1, all 13 bits are inverted, so the angle counts from the far edge of the octant.
- R5: `core_angle` and `core_valid` are registered one clock after the phase they come from. `core_valid` is 1 on every clock that is not in reset or the first clock after it.
- R6: The sine output is the two's-complement negation of the selected value when phase bit 15 of the sample is 1. Otherwise it passes unchanged.
- R7: The cosine output is negated when phase bits 15 and 14 of the sample differ. Otherwise it passes unchanged.
- R8: The core's cosine and sine are exchanged before the sign step when phase bits 14 and 13 of the sample differ.
- R9: Each corrected pair appears one clock after its `core_ret_valid`, with `out_valid` high. The corrections use the octant of the sample sent `CORE_LAT` clocks before that return. A reset discards samples that are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 16 | Phase increment per clock |
| offset_word | input | 16 | Phase offset added to the register |
| core_angle | output | 13 | First-octant angle sent to the rotation core |
| core_valid | output | 1 | Marks a sample on `core_angle` |
| core_cos | input | 16 | First-octant cosine from the core (signed) |
| core_sin | input | 16 | First-octant sine from the core (signed) |
| core_ret_valid | input | 1 | Marks a returned core pair |
| cos_out | output | 16 | Full-circle cosine (signed) |
| sin_out | output | 16 | Full-circle sine (signed) |
| out_valid | output | 1 | Marks a corrected output pair |

## Verification
The exchange and the cosine negation can apply in the same cycle. Octants 2 and 5 need both. In octant 5 the sine is negated as well. The bench provokes this with directed offsets at the start and end of every octant, and with a tuning word of one eighth of a turn, which walks through all eight octants on consecutive clocks. Random words then mix all eight octants. Each output is compared with a per-octant table written in the bench, which is built from trigonometric identities rather than from the bit rules. The stand-in core returns two different values, so a missing exchange or a sign on the wrong output shows up as a mismatch.

// File: rtl/ncof_pkg.sv
package ncof_pkg;
   localparam int OCT_W = 3;

   typedef logic [OCT_W-1:0] octant_t;

   typedef struct packed {
      logic    vld;
      octant_t oct;
   } tag_t;
endpackage

// File: rtl/ncof_accum.sv
module ncof_accum #(
   parameter int PHASE_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] step_i,
   input  logic [PHASE_W-1:0] ofs_i,
   output logic [PHASE_W-1:0] phase_o
);
   logic [PHASE_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + step_i;
   end

   assign phase_o = acc_q + ofs_i;

   // first phase after reset equals the offset alone
   AST_FIRST_PHASE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (phase_o == ofs_i)) else $error("first phase"); // R1
endmodule

// File: rtl/ncof_fold.sv
module ncof_fold
   import ncof_pkg::*;
#(
   parameter int PHASE_W = 16,
   localparam int ANG_W = PHASE_W - OCT_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] phase_i,
   output logic [ANG_W-1:0]   angle_o,
   output octant_t            oct_o,
   output logic               vld_o
);
   octant_t          oct_w;
   logic [ANG_W-1:0] low_w;
   logic [ANG_W-1:0] ang_w;

   assign oct_w = phase_i[PHASE_W-1 -: OCT_W];
   assign low_w = phase_i[ANG_W-1:0];
   assign ang_w = oct_w[0] ? ~low_w : low_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         angle_o <= '0;
         oct_o   <= '0;
         vld_o   <= 1'b0;
      end else begin
         angle_o <= ang_w;
         oct_o   <= oct_w;
         vld_o   <= 1'b1;
      end
   end

   // odd octant: angle plus its low field sums to all ones
   AST_MIRROR_SUM: assert property (@(posedge clk) disable iff (rst)
      (vld_o && oct_o[0]) |-> ((angle_o + $past(low_w)) == {ANG_W{1'b1}})) else $error("mirror"); // R4
endmodule

// File: rtl/ncof_tag_pipe.sv
module ncof_tag_pipe
   import ncof_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  tag_t tag_i,
   output tag_t tag_o
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign tag_o = tag_i;
      end else begin : g_shift
         tag_t stage_q [DEPTH];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= tag_i;
               for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
         end

         assign tag_o = stage_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/ncof_restore.sv
module ncof_restore
   import ncof_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  octant_t                  oct_i,
   input  logic signed [DATA_W-1:0] c_i,
   input  logic signed [DATA_W-1:0] s_i,
   output logic signed [DATA_W-1:0] cos_o,
   output logic signed [DATA_W-1:0] sin_o,
   output logic                     vld_o
);
   logic                     swap_w;
   logic                     neg_c_w;
   logic                     neg_s_w;
   logic signed [DATA_W-1:0] pc_w;
   logic signed [DATA_W-1:0] ps_w;

   assign swap_w  = oct_i[1] ^ oct_i[0];
   assign neg_c_w = oct_i[2] ^ oct_i[1];
   assign neg_s_w = oct_i[2];
   assign pc_w    = swap_w ? s_i : c_i;
   assign ps_w    = swap_w ? c_i : s_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         cos_o <= '0;
         sin_o <= '0;
         vld_o <= 1'b0;
      end else begin
         cos_o <= neg_c_w ? (~pc_w + 1'b1) : pc_w;
         sin_o <= neg_s_w ? (~ps_w + 1'b1) : ps_w;
         vld_o <= vld_i;
      end
   end

   function automatic logic [DATA_W-1:0] mag(input logic signed [DATA_W-1:0] x);
      return x[DATA_W-1] ? DATA_W'(-x) : DATA_W'(x);
   endfunction

   AST_SIN_SIGN: assert property (@(posedge clk) disable iff (rst)
      (vld_o && $past(c_i > 0 && s_i > 0)) |-> (sin_o[DATA_W-1] == $past(oct_i[2]))) else $error("sin sign"); // R6
   AST_COS_SIGN: assert property (@(posedge clk) disable iff (rst)
      (vld_o && $past(c_i > 0 && s_i > 0)) |-> (cos_o[DATA_W-1] == $past(oct_i[2] ^ oct_i[1]))) else $error("cos sign"); // R7
   AST_SWAP_PICK: assert property (@(posedge clk) disable iff (rst)
      (vld_o && $past(c_i > 0 && s_i > 0)) |->
      (mag(cos_o) == ($past(oct_i[1] ^ oct_i[0]) ? $past(mag(s_i)) : $past(mag(c_i))))) else $error("swap"); // R8
endmodule

// File: rtl/ncof_top.sv
module ncof_top
   import ncof_pkg::*;
#(
   parameter int PHASE_W  = 16,
   parameter int DATA_W   = 16,
   parameter int CORE_LAT = 4,
   localparam int ANG_W   = PHASE_W - OCT_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [PHASE_W-1:0]       tune_word,
   input  logic [PHASE_W-1:0]       offset_word,
   output logic [ANG_W-1:0]         core_angle,
   output logic                     core_valid,
   input  logic signed [DATA_W-1:0] core_cos,
   input  logic signed [DATA_W-1:0] core_sin,
   input  logic                     core_ret_valid,
   output logic signed [DATA_W-1:0] cos_out,
   output logic signed [DATA_W-1:0] sin_out,
   output logic                     out_valid
);
   initial begin
      AST_PARAM_PHASE: assert (PHASE_W >= OCT_W + 1) else $error("PHASE_W too small");
      AST_PARAM_DATA:  assert (DATA_W >= 2) else $error("DATA_W too small");
      AST_PARAM_LAT:   assert (CORE_LAT >= 0) else $error("CORE_LAT negative");
   end

   logic [PHASE_W-1:0] phase_w;
   octant_t            oct_q;
   tag_t               tag_in_w;
   tag_t               tag_out_w;

   ncof_accum #(.PHASE_W(PHASE_W)) u_accum (
      .clk     (clk),
      .rst     (rst),
      .step_i  (tune_word),
      .ofs_i   (offset_word),
      .phase_o (phase_w)
   );

   ncof_fold #(.PHASE_W(PHASE_W)) u_fold (
      .clk     (clk),
      .rst     (rst),
      .phase_i (phase_w),
      .angle_o (core_angle),
      .oct_o   (oct_q),
      .vld_o   (core_valid)
   );

   assign tag_in_w = '{vld: core_valid, oct: oct_q};

   ncof_tag_pipe #(.DEPTH(CORE_LAT)) u_tags (
      .clk   (clk),
      .rst   (rst),
      .tag_i (tag_in_w),
      .tag_o (tag_out_w)
   );

   ncof_restore #(.DATA_W(DATA_W)) u_restore (
      .clk   (clk),
      .rst   (rst),
      .vld_i (core_ret_valid),
      .oct_i (tag_out_w.oct),
      .c_i   (core_cos),
      .s_i   (core_sin),
      .cos_o (cos_out),
      .sin_o (sin_out),
      .vld_o (out_valid)
   );

   // a returned pair must meet a live octant tag
   AST_RET_HAS_TAG: assert property (@(posedge clk) disable iff (rst)
      core_ret_valid |-> tag_out_w.vld) else $error("untagged return"); // R9
   AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(core_ret_valid)) else $error("out without return"); // R9
endmodule

// File: tb/ncof_top_tb_top.sv
module ncof_top_tb_top;
   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] tune_word = '0;
   logic [15:0] offset_word = '0;
   logic [12:0] core_angle;
   logic        core_valid;
   logic signed [15:0] core_cos;
   logic signed [15:0] core_sin;
   logic        core_ret_valid;
   logic signed [15:0] cos_out;
   logic signed [15:0] sin_out;
   logic        out_valid;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ncof_top #(.PHASE_W(16), .DATA_W(16), .CORE_LAT(LAT)) dut_i (
      .clk(clk), .rst(rst), .tune_word(tune_word), .offset_word(offset_word),
      .core_angle(core_angle), .core_valid(core_valid),
      .core_cos(core_cos), .core_sin(core_sin), .core_ret_valid(core_ret_valid),
      .cos_out(cos_out), .sin_out(sin_out), .out_valid(out_valid)
   );

   // stand-in rotation core: fixed latency, distinct cos/sin values
   function automatic logic [15:0] mk_c(input logic [12:0] a);
      return {3'b000, a};
   endfunction
   function automatic logic [15:0] mk_s(input logic [12:0] a);
      return 16'h4000 - {3'b000, a};
   endfunction

   logic [LAT-1:0] cv_q;
   logic [15:0]    cc_q [LAT];
   logic [15:0]    cs_q [LAT];

   always @(posedge clk) begin
      if (rst) begin
         cv_q <= '0;
         for (int i = 0; i < LAT; i++) begin cc_q[i] <= '0; cs_q[i] <= '0; end
      end else begin
         cv_q[0] <= core_valid;
         cc_q[0] <= mk_c(core_angle);
         cs_q[0] <= mk_s(core_angle);
         for (int i = 1; i < LAT; i++) begin
            cv_q[i] <= cv_q[i-1]; cc_q[i] <= cc_q[i-1]; cs_q[i] <= cs_q[i-1];
         end
      end
   end
   assign core_ret_valid = cv_q[LAT-1];
   assign core_cos = cc_q[LAT-1];
   assign core_sin = cs_q[LAT-1];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // full-circle expectation from angle identities per octant
   task automatic expect_pair(input logic [2:0] o, input logic [12:0] a,
                              output logic [15:0] ec, output logic [15:0] es);
      logic [15:0] c, s;
      c = mk_c(a);
      s = mk_s(a);
      case (o)
         3'd0: begin ec = c;  es = s;  end
         3'd1: begin ec = s;  es = c;  end
         3'd2: begin ec = -s; es = c;  end
         3'd3: begin ec = -c; es = s;  end
         3'd4: begin ec = -c; es = -s; end
         3'd5: begin ec = -s; es = -c; end
         3'd6: begin ec = s;  es = -c; end
         default: begin ec = c; es = -s; end
      endcase
   endtask

   logic [15:0] m_acc = '0;
   bit          rec_v [64];
   logic [2:0]  rec_o [64];
   logic [12:0] rec_a [64];
   int          t = 0;

   task automatic step(input logic [15:0] f, input logic [15:0] p, input logic r);
      logic [15:0] ph, ec, es;
      logic [12:0] ea;
      int e;
      @(negedge clk);
      tune_word = f; offset_word = p; rst = r;
      @(posedge clk);
      #1;
      t++;
      if (r) begin
         m_acc = '0;
         for (int i = 0; i < 64; i++) rec_v[i] = 1'b0;
         chk(core_valid == 1'b0, "R1 core_valid in reset", 32'(core_valid), 0);
         chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 0);
      end else begin
         ph = m_acc + p;          // R3
         m_acc = m_acc + f;       // R2
         ea = ph[13] ? 13'(8191 - ph[12:0]) : ph[12:0];
         rec_v[t % 64] = 1'b1;
         rec_o[t % 64] = ph[15:13];
         rec_a[t % 64] = ea;
         chk(core_valid == 1'b1, "R5 core_valid", 32'(core_valid), 1);
         chk(core_angle == ea, "R2 R3 R4 core_angle", 32'(core_angle), 32'(ea));
      end
      if (t > LAT + 1) begin
         e = (t - 1 - LAT) % 64;
         chk(out_valid == rec_v[e], "R9 out_valid", 32'(out_valid), 32'(rec_v[e]));
         if (rec_v[e] && out_valid) begin
            expect_pair(rec_o[e], rec_a[e], ec, es);
            chk(cos_out == ec, "R7 R8 R9 cos_out", 32'(cos_out), 32'(ec));
            chk(sin_out == es, "R6 R8 R9 sin_out", 32'(sin_out), 32'(es));
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7331));
      for (int i = 0; i < 64; i++) rec_v[i] = 1'b0;
      // R1: reset state, then first sample uses the offset alone
      repeat (3) step(16'h1234, 16'h0000, 1'b1);
      step(16'h0100, 16'h2345, 1'b0);
      // octant edges with a frozen accumulator
      step(16'h0000, 16'h0000, 1'b1);
      for (int o = 0; o < 8; o++) begin
         step(16'h0000, 16'(o << 13), 1'b0);
         step(16'h0000, 16'((o << 13) | 16'h1FFF), 1'b0);
         step(16'h0000, 16'((o << 13) | 16'h0ABC), 1'b0);
      end
      // one octant per clock: swap and cosine sign together in octants 2 and 5
      for (int i = 0; i < 24; i++) step(16'h2000, 16'h0123, 1'b0);
      // wrap with a negative step and a half-turn step (R2)
      for (int i = 0; i < 20; i++) step(16'hFFFF, 16'h0000, 1'b0);
      for (int i = 0; i < 12; i++) step(16'h8000, 16'h1000, 1'b0);
      // reset with samples in flight (R9)
      step(16'h0777, 16'h0000, 1'b1);
      step(16'h0777, 16'h0000, 1'b1);
      for (int i = 0; i < 10; i++) step(16'h0777, 16'h5555, 1'b0);
      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] f, p;
         f = 16'($urandom);
         p = ($urandom % 4 == 0) ? 16'h0000 : 16'($urandom);
         step(f, p, ($urandom % 250) == 0);
      end
      for (int i = 0; i < LAT + 4; i++) step(16'($urandom), 16'h0000, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule